// File: doc/BRIEF.md
# Protection and Auto-Restart Supervisor

This block watches the digitised protection flags of an offline switching controller and decides when the power switch may be driven. It covers supply over-voltage, sampled output over- and under-voltage, brownout of the line sense, an external shutdown input with a startup-dependent threshold, and two current-sense faults: a shorted output diode (sense far too high) and a shorted sense resistor (sense far too low). Some faults are qualified by how long a level persists in clock cycles. Others are qualified by how many consecutive switching-cycle samples report them. The per-cycle strobe marks the instant at which the sampled flags are valid.

Once a fault qualifies, the supervisor inhibits the gate and records a fault code. It then runs a restart sequence on the supply-level flags. The supply is first allowed to fall to the startup re-enable level. The startup current source is then enabled until the supply recharges to the turn-on level, and switching resumes. An output under-voltage fault selects the extended sequence, which adds further discharge and recharge passes without switching before resuming. Analog comparators and level sensing lie outside the block.

Top module: `prot_supervisor`

## Requirements
- R1: After reset, `gate_off_o`=1, `hv_start_o`=1 and `fault_code_o`=0. The first clock edge with `vdd_on_i`=1 starts switching: `gate_off_o`=0 and `hv_start_o`=0 after that edge.
- R2: While switching, `vdd_ovp_i` held high on VDD_OVP_CLKS consecutive clock edges inhibits the gate after the last of those edges, with code 1. Any edge with the flag low restarts the count.
- R3: `out_ovp_i` high at OVP_CYCLES (default 3) consecutive strobes trips the supervisor with code 2. A strobe with the flag low restarts the count.
- R4: `out_uvp_i` high at UVP_CYCLES (default 2) consecutive strobes trips the supervisor with code 3. It is ignored during the first UVP_BLANK_CLKS clocks of every switching period.
- R5: `line_low_i` held high for BROWNOUT_CLKS consecutive edges trips the supervisor with code 4.
- R6: For the first SHDN_WIN_CLKS clocks of every switching period, the shutdown condition is `sd_below_hi_i`. After that window it is `sd_below_lo_i`. The condition held for SHDN_CLKS consecutive edges trips the supervisor with code 5.
- R7: With `fb_low_i`=1, the shutdown condition is taken live. With `fb_low_i`=0, it is the value captured at the last strobe, so a condition with no strobe never trips.
- R8: `cs_over_i` high at a single strobe trips the supervisor with code 6. `cs_under_i` high at CS_LO_CYCLES (default 3) consecutive strobes trips it with code 7.
- R9: After a fault other than under-voltage, the gate stays off and `hv_start_o`=0 until `vdd_rst_i` is seen, even if `vdd_on_i` is high. Then `hv_start_o`=1 until `vdd_on_i` is seen, after which switching resumes and the code returns to 0.
- R10: After code 3, the sequence of R9 is performed EXT_HICCUPS+1 times (default 3). For each extra pass, `vdd_on_i` returns the block to the discharge phase with the gate still off.
- R11: When several faults qualify on the same edge, the lowest code is recorded. The code does not change while the gate is inhibited, and no fault is detected while the gate is inhibited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_stb_i | input | 1 | One-clock strobe per switching cycle, sampled flags valid |
| fb_low_i | input | 1 | Feedback below the burst-low level |
| vdd_ovp_i | input | 1 | Supply above the over-voltage level |
| out_ovp_i | input | 1 | Sampled output above the over-voltage level |
| out_uvp_i | input | 1 | Sampled output below the under-voltage level |
| line_low_i | input | 1 | Line-sense current below the brownout level |
| sd_below_hi_i | input | 1 | Shutdown pin below the startup threshold |
| sd_below_lo_i | input | 1 | Shutdown pin below the running threshold |
| cs_over_i | input | 1 | Current sense above the diode-short level |
| cs_under_i | input | 1 | Current sense below the sense-short level |
| vdd_on_i | input | 1 | Supply at or above turn-on |
| vdd_rst_i | input | 1 | Supply at or below startup re-enable |
| gate_off_o | output | 1 | Gate inhibit |
| hv_start_o | output | 1 | Startup current source enable |
| fault_code_o | output | 3 | Recorded fault code, 0 when none |

## Verification
A debounce counter that does not clear on a lapse, or that compares against the wrong limit, shows up on `gate_off_o` exactly one edge early or late relative to the qualifying edge. The bench therefore samples on both sides of that edge. A wrong restart state shows as `hv_start_o` at the wrong level in the first cycle after a supply flag. It can also show as the gate resuming one supply pass early in extended mode, which the bench checks after every pass. A wrong window or sampling choice for the shutdown input appears only in the code and in the trip timing, so both are compared against bench-computed values.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int NFLT = 7;

  typedef enum logic [1:0] {
    ST_CHARGE = 2'd0,
    ST_RUN    = 2'd1,
    ST_DRAIN  = 2'd2
  } rs_state_t;

  localparam logic [2:0] CODE_NONE = 3'd0;
  localparam int IDX_UVP = 2;

  // lowest set index wins; code is index + 1
  function automatic logic [2:0] first_fault(input logic [NFLT-1:0] v);
    logic [2:0] c;
    c = CODE_NONE;
    for (int i = NFLT - 1; i >= 0; i--)
      if (v[i]) c = 3'(i + 1);
    return c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/prot_debounce.sv
module prot_debounce #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stb,
  input  logic flag,
  output logic trip
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!en)
      cnt <= '0;
    else if (stb) begin
      if (!flag)
        cnt <= '0;
      else if (cnt < LAST)
        cnt <= cnt + 1'b1;
    end
  end

  assign trip = en && stb && flag && (cnt == LAST);
endmodule

// File: rtl/prot_sd_select.sv
module prot_sd_select (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stb,
  input  logic fb_low,
  input  logic in_window,
  input  logic below_hi,
  input  logic below_lo,
  output logic sd_cond
);
  logic level_now;
  logic level_held;

  assign level_now = in_window ? below_hi : below_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      level_held <= 1'b0;
    else if (!en)
      level_held <= 1'b0;
    else if (stb)
      level_held <= level_now;
  end

  assign sd_cond = fb_low ? level_now : level_held;
endmodule

// File: rtl/prot_restart_fsm.sv
module prot_restart_fsm
  import prot_pkg::*;
#(
  parameter int EXT_HICCUPS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_trip,
  input  logic ext_req,
  input  logic vdd_on,
  input  logic vdd_rst,
  output logic run,
  output logic resume,
  output logic hv_start
);
  localparam int HW = (EXT_HICCUPS < 2) ? 1 : $clog2(EXT_HICCUPS + 1);

  rs_state_t     st;
  logic [HW-1:0] hic_left;

  assign run      = (st == ST_RUN);
  assign hv_start = (st == ST_CHARGE);
  assign resume   = (st == ST_CHARGE) && vdd_on && (hic_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_CHARGE;
      hic_left <= '0;
    end else begin
      case (st)
        ST_RUN: if (any_trip) begin
          st       <= ST_DRAIN;
          hic_left <= ext_req ? HW'(EXT_HICCUPS) : '0;
        end
        ST_DRAIN: if (vdd_rst) st <= ST_CHARGE;
        ST_CHARGE: if (vdd_on) begin
          if (hic_left == '0) st <= ST_RUN;
          else begin
            hic_left <= hic_left - 1'b1;
            st       <= ST_DRAIN;
          end
        end
        default: st <= ST_CHARGE;
      endcase
    end
  end
endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
  import prot_pkg::*;
#(
  parameter int VDD_OVP_CLKS   = 70,
  parameter int BROWNOUT_CLKS  = 16500,
  parameter int SHDN_CLKS      = 400,
  parameter int SHDN_WIN_CLKS  = 1000,
  parameter int UVP_BLANK_CLKS = 40000,
  parameter int OVP_CYCLES     = 3,
  parameter int UVP_CYCLES     = 2,
  parameter int CS_HI_CYCLES   = 1,
  parameter int CS_LO_CYCLES   = 3,
  parameter int EXT_HICCUPS    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_stb_i,
  input  logic       fb_low_i,
  input  logic       vdd_ovp_i,
  input  logic       out_ovp_i,
  input  logic       out_uvp_i,
  input  logic       line_low_i,
  input  logic       sd_below_hi_i,
  input  logic       sd_below_lo_i,
  input  logic       cs_over_i,
  input  logic       cs_under_i,
  input  logic       vdd_on_i,
  input  logic       vdd_rst_i,
  output logic       gate_off_o,
  output logic       hv_start_o,
  output logic [2:0] fault_code_o
);
  localparam int SINCE_MAX = max_of(UVP_BLANK_CLKS, SHDN_WIN_CLKS);
  localparam int SW = $clog2(SINCE_MAX + 1);
  localparam int LIM [NFLT] = '{VDD_OVP_CLKS, OVP_CYCLES, UVP_CYCLES,
                                 BROWNOUT_CLKS, SHDN_CLKS, CS_HI_CYCLES,
                                 CS_LO_CYCLES};
  localparam logic [NFLT-1:0] PER_CYCLE = 7'b1100110;

  logic            run_w, resume_w, hv_w;
  logic            uvp_armed_w, sd_window_w, sd_cond_w;
  logic            any_trip_w;
  logic [NFLT-1:0] flag_v, en_v, trip_v;
  logic [SW-1:0]   since;
  logic [2:0]      code_q;

  // clocks spent switching since the last start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   since <= '0;
    else if (!run_w)              since <= '0;
    else if (since < SW'(SINCE_MAX)) since <= since + 1'b1;
  end

  assign uvp_armed_w = (since >= SW'(UVP_BLANK_CLKS));
  assign sd_window_w = (since <  SW'(SHDN_WIN_CLKS));

  prot_sd_select u_sd (
    .clk(clk), .rst_n(rst_n), .en(run_w), .stb(cyc_stb_i),
    .fb_low(fb_low_i), .in_window(sd_window_w),
    .below_hi(sd_below_hi_i), .below_lo(sd_below_lo_i),
    .sd_cond(sd_cond_w)
  );

  assign flag_v = {cs_under_i, cs_over_i, sd_cond_w, line_low_i,
                   out_uvp_i, out_ovp_i, vdd_ovp_i};

  for (genvar g = 0; g < NFLT; g++) begin : g_deb
    assign en_v[g] = (g == IDX_UVP) ? (run_w && uvp_armed_w) : run_w;
    prot_debounce #(.LIMIT(LIM[g])) u_deb (
      .clk(clk), .rst_n(rst_n), .en(en_v[g]),
      .stb(PER_CYCLE[g] ? cyc_stb_i : 1'b1),
      .flag(flag_v[g]), .trip(trip_v[g])
    );
  end

  assign any_trip_w = |trip_v;

  prot_restart_fsm #(.EXT_HICCUPS(EXT_HICCUPS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .any_trip(any_trip_w),
    .ext_req(first_fault(trip_v) == 3'(IDX_UVP + 1)),
    .vdd_on(vdd_on_i), .vdd_rst(vdd_rst_i),
    .run(run_w), .resume(resume_w), .hv_start(hv_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    code_q <= CODE_NONE;
    else if (resume_w)             code_q <= CODE_NONE;
    else if (run_w && any_trip_w)  code_q <= first_fault(trip_v);
  end

  assign gate_off_o   = !run_w;
  assign hv_start_o   = hv_w;
  assign fault_code_o = code_q;
endmodule

// File: rtl/prot_supervisor_chk.sv
module prot_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gate_off_o,
  input logic       hv_start_o,
  input logic [2:0] fault_code_o,
  input logic       vdd_on_i,
  input logic       vdd_rst_i,
  input logic       cyc_stb_i,
  input logic       cs_over_i,
  input logic       any_trip_w
);
  assert_trip_halts_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (any_trip_w && !gate_off_o) |=> gate_off_o);

  assert_cs_over_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_off_o && cyc_stb_i && cs_over_i) |=> (gate_off_o && fault_code_o != 3'd0));

  assert_drain_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_off_o && !hv_start_o && !vdd_rst_i) |=> (gate_off_o && !hv_start_o));

  assert_resume_after_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_off_o) |-> $past(vdd_on_i && hv_start_o));

  assert_code_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_off_o && $past(gate_off_o)) |-> $stable(fault_code_o));

  assert_start_off_when_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_off_o |-> !hv_start_o);
endmodule

bind prot_supervisor prot_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gate_off_o(gate_off_o), .hv_start_o(hv_start_o),
  .fault_code_o(fault_code_o), .vdd_on_i(vdd_on_i), .vdd_rst_i(vdd_rst_i),
  .cyc_stb_i(cyc_stb_i), .cs_over_i(cs_over_i), .any_trip_w(any_trip_w)
);

// File: tb/tb_prot_supervisor.sv
module tb_prot_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int VOVP = 8, BO = 40, SDC = 6, SDW = 30, UBL = 60;

  logic clk = 0, rst_n = 0;
  logic stb = 0, fb_low = 1, vovp = 0, oovp = 0, ouvp = 0, llow = 0;
  logic sdh = 0, sdl = 0, csov = 0, csun = 0, von = 0, vrst = 0;
  logic gate_off, hv_start;
  logic [2:0] code;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_supervisor #(.VDD_OVP_CLKS(VOVP), .BROWNOUT_CLKS(BO), .SHDN_CLKS(SDC),
    .SHDN_WIN_CLKS(SDW), .UVP_BLANK_CLKS(UBL)) dut (
    .clk(clk), .rst_n(rst_n), .cyc_stb_i(stb), .fb_low_i(fb_low),
    .vdd_ovp_i(vovp), .out_ovp_i(oovp), .out_uvp_i(ouvp), .line_low_i(llow),
    .sd_below_hi_i(sdh), .sd_below_lo_i(sdl), .cs_over_i(csov),
    .cs_under_i(csun), .vdd_on_i(von), .vdd_rst_i(vrst),
    .gate_off_o(gate_off), .hv_start_o(hv_start), .fault_code_o(code));

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic strobe();
    stb = 1; tick(); stb = 0;
  endtask

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench view of priority among cycle faults tripping on the third strobe or earlier
  function automatic int exp_code(bit ov, bit cso, bit csu);
    if (cso) return 6;
    if (ov)  return 2;
    if (csu) return 7;
    return 0;
  endfunction

  task automatic restart_normal(string req);
    vrst = 1; tick(); vrst = 0;
    chk({req, " charge hv_start"}, hv_start, 1);
    chk({req, " charge gate_off"}, gate_off, 1);
    von = 1; tick(); von = 0;
    chk({req, " resumed"}, gate_off, 0);
    chk({req, " code cleared"}, code, 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    tick(3);
    chk("R1 reset gate_off", gate_off, 1);
    chk("R1 reset hv_start", hv_start, 1);
    chk("R1 reset code", code, 0);
    rst_n = 1; tick(2);
    chk("R1 waits for turn-on", gate_off, 1);
    von = 1; tick(); von = 0;
    chk("R1 running", gate_off, 0);
    chk("R1 startup off", hv_start, 0);

    // R6 startup threshold in window, live mode
    sdh = 1; tick(SDC - 1);
    chk("R6 window before limit", gate_off, 0);
    tick();
    chk("R6 window trip", gate_off, 1);
    chk("R6 window code", code, 5);
    chk("R9 drain no startup", hv_start, 0);
    sdh = 0; von = 1; tick(4); von = 0;
    chk("R9 turn-on ignored while draining", gate_off, 1);
    chk("R11 code held", code, 5);
    restart_normal("R9");

    // R6 after window only low threshold counts
    tick(SDW + 10);
    sdh = 1; tick(20);
    chk("R6 high threshold ignored after window", gate_off, 0);
    sdl = 1; tick(SDC - 1);
    chk("R6 low threshold before limit", gate_off, 0);
    tick();
    chk("R6 low threshold trip", code, 5);
    sdh = 0; sdl = 0;
    restart_normal("R6");

    // R7 sampled mode
    tick(SDW + 10);
    fb_low = 0; sdh = 1; sdl = 1; tick(25);
    chk("R7 no strobe no trip", gate_off, 0);
    strobe(); tick(SDC - 1);
    chk("R7 before limit", gate_off, 0);
    tick();
    chk("R7 sampled trip", code, 5);
    sdh = 0; sdl = 0; fb_low = 1;
    restart_normal("R7");

    // R2 supply over-voltage with lapse
    vovp = 1; tick(VOVP - 1); vovp = 0; tick(); vovp = 1; tick(VOVP - 1);
    chk("R2 lapse clears count", gate_off, 0);
    tick();
    chk("R2 trip", gate_off, 1);
    chk("R2 code", code, 1);
    vovp = 0;
    restart_normal("R2");

    // R3 output over-voltage
    oovp = 1; strobe(); strobe(); oovp = 0; strobe(); oovp = 1; strobe(); strobe();
    chk("R3 lapse clears count", gate_off, 0);
    tick(5);
    chk("R3 no strobe no count", gate_off, 0);
    strobe();
    chk("R3 trip", code, 2);
    oovp = 0;
    restart_normal("R3");

    // R5 brownout
    llow = 1; tick(BO - 1);
    chk("R5 before limit", gate_off, 0);
    tick();
    chk("R5 trip", code, 4);
    llow = 0;
    restart_normal("R5");

    // R8 current sense
    csov = 1; strobe(); csov = 0;
    chk("R8 diode short trip", code, 6);
    restart_normal("R8a");
    csun = 1; strobe(); strobe();
    chk("R8 sense short before limit", gate_off, 0);
    strobe(); csun = 0;
    chk("R8 sense short trip", code, 7);
    restart_normal("R8b");

    // R4 blanking then extended restart R10
    ouvp = 1; for (int i = 0; i < 4; i++) strobe();
    chk("R4 blanked", gate_off, 0);
    ouvp = 0; tick(UBL + 5);
    ouvp = 1; strobe();
    chk("R4 before limit", gate_off, 0);
    strobe(); ouvp = 0;
    chk("R4 trip", code, 3);
    for (int p = 0; p < 2; p++) begin
      vrst = 1; tick(); vrst = 0;
      chk("R10 charge pass", hv_start, 1);
      von = 1; tick(); von = 0;
      chk("R10 extra pass gate off", gate_off, 1);
      chk("R10 extra pass back to drain", hv_start, 0);
    end
    restart_normal("R10");

    // R11 random simultaneous cycle faults
    for (int it = 0; it < 24; it++) begin
      bit a, b, c;
      int e;
      a = 1'($urandom()); b = 1'($urandom()); c = 1'($urandom());
      e = exp_code(a, b, c);
      oovp = a; csov = b; csun = c;
      strobe(); strobe(); strobe();
      oovp = 0; csov = 0; csun = 0;
      chk("R11 priority code", code, e);
      chk("R11 gate state", gate_off, (e != 0) ? 1 : 0);
      if (e != 0) restart_normal("R11");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule